// File: doc/BRIEF.md
# Multi-Channel DMA Register and Interrupt Bank

This block is the software-visible control bank of a sixteen-channel DMA engine. A host reaches it through a simple word read/write bus. The bank keeps each channel's start address, X length, Y length, control bits and line stride. It sends that configuration to the address generators as flat vectors, together with one-cycle start and stop strobes.

The bank also collects completion or half-buffer events from the channels. It latches them into a sticky status register and drives one combined interrupt line, which is gated per channel by an enable mask. A channel is launched by writing its address register, after its other registers have been set up. A channel is halted through a shared write-only register in which each set bit stops one channel. Cyclic operation is granted to a channel only when two matching bits of the loop register are both set.

Top module: `dmac_regbank`

## Requirements
- R1: Channel n (0..15) has four word registers at byte offset n*0x10: address at +0x0 (32 bits), X length at +0x4 and Y length at +0x8 (16 bits each, upper bits read 0), and control at +0xC (bits [5:0] kept, higher bits read 0). All are readable, and the values appear on ch_addr, ch_xlen and ch_ylen. In the control register bit 4 = 1 selects 4-word bursts (ch_burst), bit 5 = 1 selects memory-to-device direction (ch_dir), and bits [3:0] hold a channel number.
- R2: The 16-bit stride register of channel n is at byte offset 0x100 + 4*n. It is readable and appears on ch_stride.
- R3: A write to the address register of channel n makes ch_start[n] high for exactly the one cycle after the write edge, with no other start bit set. In that cycle ch_addr already shows the new address.
- R4: Writing to offset 0x140 makes ch_stop[n] high for the one cycle after the write, for every bit n of the data that is 1. The offset always reads 0.
- R5: The interrupt status register at 0x144 has one bit per channel. A high ev_in[n] in a cycle sets bit n at that edge, whether or not bit n is enabled.
- R6: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. If an event and a write-1 clear reach the same bit in the same cycle, the bit stays set.
- R7: The interrupt enable register at 0x148 has one bit per channel. irq is high exactly while some status bit and its enable bit are both 1.
- R8: For the loop register at 0x150, ch_loop[n] is 1 only while both bit n and bit n+16 are set. The register reads back those bits, with the others at 0.
- R9: A read of an offset not listed above, or of one that is not word aligned, returns 0. A write to such an offset changes no register and no output.
- R10: Read data is registered: rdata shows the addressed value in the cycle after rd_en is sampled, and 0 in every other cycle.
- R11: After reset every register, strobe, rdata and irq are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe for the current address |
| rd_en | input | 1 | Read strobe for the current address |
| addr | input | 9 | Byte offset into the bank |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| ev_in | input | 16 | Per-channel completion or half-buffer event pulses |
| ch_addr | output | 512 | Start address of each channel, channel n at bits [32n+31:32n] |
| ch_xlen | output | 256 | X length of each channel, 16 bits per channel |
| ch_ylen | output | 256 | Y length of each channel, 16 bits per channel |
| ch_stride | output | 256 | Line stride of each channel, 16 bits per channel |
| ch_burst | output | 16 | Burst mode bit of each channel |
| ch_dir | output | 16 | Direction bit of each channel |
| ch_loop | output | 16 | Loop mode granted to each channel |
| ch_start | output | 16 | One-cycle launch strobes |
| ch_stop | output | 16 | One-cycle terminate strobes |
| irq | output | 1 | Combined interrupt |

## Verification
The collision that matters is a channel event arriving in the same cycle as a host write-1 clear of the status register. The bench raises ev_in on one channel while the same write clears that bit and a second set bit. It then reads the status back through the scoreboard and expects the event's bit to stay set and only the other bit to be cleared. The irq line is judged against the enable mask before and after that collision.

// File: rtl/dmac_pkg.sv
package dmac_pkg;

    localparam int BUS_AW     = 9;
    localparam int BUS_DW     = 32;
    localparam int MAX_CH     = 16;
    localparam int CTRL_W     = 6;
    localparam int BURST_BIT  = 4;
    localparam int DIR_BIT    = 5;

    localparam logic [BUS_AW-1:0] OFF_STRIDE = 9'h100;
    localparam logic [BUS_AW-1:0] OFF_VALID  = 9'h140;
    localparam logic [BUS_AW-1:0] OFF_STAT   = 9'h144;
    localparam logic [BUS_AW-1:0] OFF_INTEN  = 9'h148;
    localparam logic [BUS_AW-1:0] OFF_LOOP   = 9'h150;

    typedef enum logic [1:0] {
        CR_ADDR = 2'd0,
        CR_XLEN = 2'd1,
        CR_YLEN = 2'd2,
        CR_CTRL = 2'd3
    } chreg_e;

endpackage

// File: rtl/dmac_chan_regs.sv
module dmac_chan_regs
    import dmac_pkg::*;
#(
    parameter int CH_AW    = 32,
    parameter int LEN_W    = 16,
    parameter int STRIDE_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_addr,
    input  logic                wr_xlen,
    input  logic                wr_ylen,
    input  logic                wr_ctrl,
    input  logic                wr_stride,
    input  logic [BUS_DW-1:0]   wdata,
    output logic [CH_AW-1:0]    addr_o,
    output logic [LEN_W-1:0]    xlen_o,
    output logic [LEN_W-1:0]    ylen_o,
    output logic [CTRL_W-1:0]   ctrl_o,
    output logic [STRIDE_W-1:0] stride_o,
    output logic                start_o
);

    typedef struct packed {
        logic [CH_AW-1:0]    addr;
        logic [LEN_W-1:0]    xlen;
        logic [LEN_W-1:0]    ylen;
        logic [CTRL_W-1:0]   ctrl;
        logic [STRIDE_W-1:0] stride;
        logic                start;
    } chan_t;

    chan_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.start = wr_addr;
        if (wr_addr)   st_d.addr   = wdata[CH_AW-1:0];
        if (wr_xlen)   st_d.xlen   = wdata[LEN_W-1:0];
        if (wr_ylen)   st_d.ylen   = wdata[LEN_W-1:0];
        if (wr_ctrl)   st_d.ctrl   = wdata[CTRL_W-1:0];
        if (wr_stride) st_d.stride = wdata[STRIDE_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign addr_o   = st_q.addr;
    assign xlen_o   = st_q.xlen;
    assign ylen_o   = st_q.ylen;
    assign ctrl_o   = st_q.ctrl;
    assign stride_o = st_q.stride;
    assign start_o  = st_q.start;

endmodule

// File: rtl/dmac_irq_ctrl.sv
module dmac_irq_ctrl #(
    parameter int NUM_CH = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stat,
    input  logic              wr_inten,
    input  logic [NUM_CH-1:0] wdata,
    input  logic [NUM_CH-1:0] ev_in,
    output logic [NUM_CH-1:0] status_o,
    output logic [NUM_CH-1:0] enable_o,
    output logic              irq_o
);

    typedef struct packed {
        logic [NUM_CH-1:0] status;
        logic [NUM_CH-1:0] enable;
    } irq_t;

    irq_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_stat)  st_d.status = st_q.status & ~wdata;
        // an event in the same cycle as a clear keeps its bit set
        st_d.status = st_d.status | ev_in;
        if (wr_inten) st_d.enable = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign status_o = st_q.status;
    assign enable_o = st_q.enable;
    assign irq_o    = |(st_q.status & st_q.enable);

endmodule

// File: rtl/dmac_loop_stop.sv
module dmac_loop_stop
    import dmac_pkg::*;
#(
    parameter int NUM_CH = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_loop,
    input  logic              wr_valid,
    input  logic [BUS_DW-1:0] wdata,
    output logic [NUM_CH-1:0] loop_lo_o,
    output logic [NUM_CH-1:0] loop_hi_o,
    output logic [NUM_CH-1:0] ch_loop_o,
    output logic [NUM_CH-1:0] stop_o
);

    localparam int HI_BASE = MAX_CH;

    typedef struct packed {
        logic [NUM_CH-1:0] lo;
        logic [NUM_CH-1:0] hi;
        logic [NUM_CH-1:0] stop;
    } ls_t;

    ls_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.stop = wr_valid ? wdata[NUM_CH-1:0] : '0;
        if (wr_loop) begin
            st_d.lo = wdata[NUM_CH-1:0];
            st_d.hi = wdata[HI_BASE +: NUM_CH];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar i = 0; i < NUM_CH; i++) begin : g_pair
        assign ch_loop_o[i] = st_q.lo[i] & st_q.hi[i];
    end

    assign loop_lo_o = st_q.lo;
    assign loop_hi_o = st_q.hi;
    assign stop_o    = st_q.stop;

endmodule

// File: rtl/dmac_regbank.sv
module dmac_regbank
    import dmac_pkg::*;
#(
    parameter int NUM_CH   = 16,
    parameter int CH_AW    = 32,
    parameter int LEN_W    = 16,
    parameter int STRIDE_W = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic                         rd_en,
    input  logic [BUS_AW-1:0]            addr,
    input  logic [BUS_DW-1:0]            wdata,
    output logic [BUS_DW-1:0]            rdata,
    input  logic [NUM_CH-1:0]            ev_in,
    output logic [NUM_CH*CH_AW-1:0]      ch_addr,
    output logic [NUM_CH*LEN_W-1:0]      ch_xlen,
    output logic [NUM_CH*LEN_W-1:0]      ch_ylen,
    output logic [NUM_CH*STRIDE_W-1:0]   ch_stride,
    output logic [NUM_CH-1:0]            ch_burst,
    output logic [NUM_CH-1:0]            ch_dir,
    output logic [NUM_CH-1:0]            ch_loop,
    output logic [NUM_CH-1:0]            ch_start,
    output logic [NUM_CH-1:0]            ch_stop,
    output logic                         irq
);

    localparam int SEL_W   = 4;
    localparam int LOOP_HI = MAX_CH;

    // ---------------- address decode ----------------
    logic             aligned;
    logic             in_ch;
    logic             in_stride;
    logic [SEL_W-1:0] ch_sel;
    logic [SEL_W-1:0] st_sel;
    chreg_e           reg_sel;
    logic             hit_valid, hit_stat, hit_inten, hit_loop;

    always_comb begin
        aligned   = (addr[1:0] == 2'b00);
        ch_sel    = addr[7:4];
        st_sel    = addr[5:2];
        reg_sel   = chreg_e'(addr[3:2]);
        in_ch     = aligned && !addr[8] && (int'(ch_sel) < NUM_CH);
        in_stride = aligned && addr[8] && (addr[7:6] == 2'b00) && (int'(st_sel) < NUM_CH);
        hit_valid = (addr == OFF_VALID);
        hit_stat  = (addr == OFF_STAT);
        hit_inten = (addr == OFF_INTEN);
        hit_loop  = (addr == OFF_LOOP);
    end

    // ---------------- per-channel registers ----------------
    logic [CH_AW-1:0]    c_addr   [MAX_CH];
    logic [LEN_W-1:0]    c_xlen   [MAX_CH];
    logic [LEN_W-1:0]    c_ylen   [MAX_CH];
    logic [CTRL_W-1:0]   c_ctrl   [MAX_CH];
    logic [STRIDE_W-1:0] c_stride [MAX_CH];

    for (genvar i = 0; i < MAX_CH; i++) begin : g_ch
        if (i < NUM_CH) begin : g_real
            logic sel_ch, sel_st;
            assign sel_ch = wr_en && in_ch && (ch_sel == SEL_W'(i));
            assign sel_st = wr_en && in_stride && (st_sel == SEL_W'(i));

            dmac_chan_regs #(
                .CH_AW    (CH_AW),
                .LEN_W    (LEN_W),
                .STRIDE_W (STRIDE_W)
            ) u_chan (
                .clk       (clk),
                .rst_n     (rst_n),
                .wr_addr   (sel_ch && (reg_sel == CR_ADDR)),
                .wr_xlen   (sel_ch && (reg_sel == CR_XLEN)),
                .wr_ylen   (sel_ch && (reg_sel == CR_YLEN)),
                .wr_ctrl   (sel_ch && (reg_sel == CR_CTRL)),
                .wr_stride (sel_st),
                .wdata     (wdata),
                .addr_o    (c_addr[i]),
                .xlen_o    (c_xlen[i]),
                .ylen_o    (c_ylen[i]),
                .ctrl_o    (c_ctrl[i]),
                .stride_o  (c_stride[i]),
                .start_o   (ch_start[i])
            );

            assign ch_addr[i*CH_AW +: CH_AW]         = c_addr[i];
            assign ch_xlen[i*LEN_W +: LEN_W]         = c_xlen[i];
            assign ch_ylen[i*LEN_W +: LEN_W]         = c_ylen[i];
            assign ch_stride[i*STRIDE_W +: STRIDE_W] = c_stride[i];
            assign ch_burst[i]                       = c_ctrl[i][BURST_BIT];
            assign ch_dir[i]                         = c_ctrl[i][DIR_BIT];
        end else begin : g_absent
            assign c_addr[i]   = '0;
            assign c_xlen[i]   = '0;
            assign c_ylen[i]   = '0;
            assign c_ctrl[i]   = '0;
            assign c_stride[i] = '0;
        end
    end

    // ---------------- shared registers ----------------
    logic [NUM_CH-1:0] stat_w;
    logic [NUM_CH-1:0] inten_w;
    logic [NUM_CH-1:0] loop_lo_w;
    logic [NUM_CH-1:0] loop_hi_w;

    dmac_irq_ctrl #(
        .NUM_CH (NUM_CH)
    ) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_stat  (wr_en && hit_stat),
        .wr_inten (wr_en && hit_inten),
        .wdata    (wdata[NUM_CH-1:0]),
        .ev_in    (ev_in),
        .status_o (stat_w),
        .enable_o (inten_w),
        .irq_o    (irq)
    );

    dmac_loop_stop #(
        .NUM_CH (NUM_CH)
    ) u_loop (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_loop   (wr_en && hit_loop),
        .wr_valid  (wr_en && hit_valid),
        .wdata     (wdata),
        .loop_lo_o (loop_lo_w),
        .loop_hi_o (loop_hi_w),
        .ch_loop_o (ch_loop),
        .stop_o    (ch_stop)
    );

    // ---------------- read path ----------------
    typedef struct packed {
        logic [BUS_DW-1:0] rdata;
    } rd_t;

    rd_t rd_d, rd_q;

    always_comb begin
        rd_d = '0;
        if (rd_en) begin
            if (in_ch) begin
                unique case (reg_sel)
                    CR_ADDR: rd_d.rdata = BUS_DW'(c_addr[ch_sel]);
                    CR_XLEN: rd_d.rdata = BUS_DW'(c_xlen[ch_sel]);
                    CR_YLEN: rd_d.rdata = BUS_DW'(c_ylen[ch_sel]);
                    CR_CTRL: rd_d.rdata = BUS_DW'(c_ctrl[ch_sel]);
                    default: rd_d.rdata = '0;
                endcase
            end else if (in_stride) begin
                rd_d.rdata = BUS_DW'(c_stride[st_sel]);
            end else if (hit_stat) begin
                rd_d.rdata = BUS_DW'(stat_w);
            end else if (hit_inten) begin
                rd_d.rdata = BUS_DW'(inten_w);
            end else if (hit_loop) begin
                rd_d.rdata[NUM_CH-1:0]        = loop_lo_w;
                rd_d.rdata[LOOP_HI +: NUM_CH] = loop_hi_w;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign rdata = rd_q.rdata;

endmodule

// File: rtl/dmac_regbank_chk.sv
module dmac_regbank_chk
    import dmac_pkg::*;
#(
    parameter int NUM_CH = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic              rd_en,
    input logic [BUS_AW-1:0] addr,
    input logic [BUS_DW-1:0] rdata,
    input logic [NUM_CH-1:0] ev_in,
    input logic [NUM_CH-1:0] ch_start,
    input logic [NUM_CH-1:0] ch_stop,
    input logic [NUM_CH-1:0] ch_loop,
    input logic [NUM_CH-1:0] stat_w
);

    // R3: a start strobe follows a write and names one channel
    a_r3_start_single: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_start != '0) |-> ($past(wr_en) && $onehot(ch_start)));

    // R4: stop strobes only follow a write to the terminate offset
    a_r4_stop_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_stop != '0) |-> $past(wr_en && (addr == OFF_VALID)));

    // R5: an event is visible in status one edge later
    a_r5_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_in != '0) |=> ((stat_w & $past(ev_in)) == $past(ev_in)));

    // R6: without a clear write, no status bit falls
    a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wr_en && (addr == OFF_STAT)) |-> ((stat_w & $past(stat_w)) == $past(stat_w)));

    // R8: loop grants move only after a loop register write
    a_r8_loop_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wr_en && (addr == OFF_LOOP)) |-> $stable(ch_loop));

    // R10: read data is zero when no read was sampled
    a_r10_rdata_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rd_en) |-> (rdata == '0));

endmodule

bind dmac_regbank dmac_regbank_chk #(
    .NUM_CH (NUM_CH)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .addr     (addr),
    .rdata    (rdata),
    .ev_in    (ev_in),
    .ch_start (ch_start),
    .ch_stop  (ch_stop),
    .ch_loop  (ch_loop),
    .stat_w   (stat_w)
);

// File: tb/sim_dmac_regbank.sv
`timescale 1ns/1ps
module sim_dmac_regbank;

    localparam int NC = 16;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           wr_en = 1'b0;
    logic           rd_en = 1'b0;
    logic [8:0]     addr = '0;
    logic [31:0]    wdata = '0;
    logic [31:0]    rdata;
    logic [NC-1:0]  ev_in = '0;
    logic [NC*32-1:0] ch_addr;
    logic [NC*16-1:0] ch_xlen, ch_ylen, ch_stride;
    logic [NC-1:0]  ch_burst, ch_dir, ch_loop, ch_start, ch_stop;
    logic           irq;

    always #2.5 clk = ~clk;

    dmac_regbank u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .ev_in(ev_in), .ch_addr(ch_addr),
        .ch_xlen(ch_xlen), .ch_ylen(ch_ylen), .ch_stride(ch_stride),
        .ch_burst(ch_burst), .ch_dir(ch_dir), .ch_loop(ch_loop),
        .ch_start(ch_start), .ch_stop(ch_stop), .irq(irq)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic        rd_seen = 1'b0;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    // monitor: compares registered read data against the scoreboard
    always @(posedge clk) rd_seen <= rd_en;
    always @(negedge clk) begin
        if (rd_seen) begin
            if (exp_q.size() == 0) begin
                check("R10 unexpected read", rdata, 32'h0);
            end else begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(t, rdata, e);
            end
        end
    end

    task automatic bus_write(input logic [8:0] a, input logic [31:0] d, input logic [NC-1:0] ev);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d; ev_in = ev;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0; ev_in = '0;
    endtask

    task automatic pulse_event(input logic [NC-1:0] ev);
        @(negedge clk);
        ev_in = ev;
        @(posedge clk);
        @(negedge clk);
        ev_in = '0;
    endtask

    task automatic bus_read(input logic [8:0] a, input logic [31:0] e, input string tag);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(posedge clk);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        #400000;
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11: reset state
        check("R11 rdata", rdata, 0);
        check("R11 irq", {31'b0, irq}, 0);
        check("R11 strobes", {ch_start, ch_stop}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R11 loop", {16'b0, ch_loop}, 0);
        bus_read(9'h144, 32'h0, "R11 status");
        bus_read(9'h050, 32'h0, "R11 ch5 addr");

        // R1: channel registers
        bus_write(9'h054, 32'hABCD_1234, '0);
        bus_write(9'h058, 32'h0000_0077, '0);
        bus_write(9'h05C, 32'hFFFF_FFF5, '0);
        bus_read(9'h054, 32'h0000_1234, "R1 xlen");
        bus_read(9'h058, 32'h0000_0077, "R1 ylen");
        bus_read(9'h05C, 32'h0000_0035, "R1 ctrl");
        check("R1 xlen out", {16'b0, ch_xlen[5*16 +: 16]}, 32'h1234);
        check("R1 ylen out", {16'b0, ch_ylen[5*16 +: 16]}, 32'h0077);
        check("R1 burst/dir", {30'b0, ch_burst[5], ch_dir[5]}, 32'h3);
        check("R1 other ch ctrl", {30'b0, ch_burst[4], ch_dir[4]}, 32'h0);
        bus_write(9'h0CC, 32'h0000_0010, '0);
        check("R1 ch12 burst only", {30'b0, ch_burst[12], ch_dir[12]}, 32'h2);

        // R2: stride
        bus_write(9'h13C, 32'h0000_0020, '0);
        bus_write(9'h100, 32'h0000_0004, '0);
        bus_read(9'h13C, 32'h0000_0020, "R2 ch15 stride");
        bus_read(9'h100, 32'h0000_0004, "R2 ch0 stride");
        check("R2 stride out", {16'b0, ch_stride[15*16 +: 16]}, 32'h20);

        // R3: launch by address write
        bus_write(9'h050, 32'h8000_1000, '0);
        check("R3 start pulse", {16'b0, ch_start}, 32'h0000_0020);
        check("R3 addr ready", ch_addr[5*32 +: 32], 32'h8000_1000);
        @(negedge clk);
        check("R3 start one cycle", {16'b0, ch_start}, 0);
        bus_read(9'h050, 32'h8000_1000, "R3 addr readback");
        bus_write(9'h054, 32'h0000_0001, '0);
        check("R3 no start on xlen", {16'b0, ch_start}, 0);

        // R4: terminate
        bus_write(9'h140, 32'h0000_8002, '0);
        check("R4 stop pulse", {16'b0, ch_stop}, 32'h0000_8002);
        @(negedge clk);
        check("R4 stop one cycle", {16'b0, ch_stop}, 0);
        bus_read(9'h140, 32'h0, "R4 reads zero");

        // R5 / R7: event while disabled, then enabled
        pulse_event(16'h0008);
        check("R5 irq masked", {31'b0, irq}, 0);
        bus_read(9'h144, 32'h0000_0008, "R5 status set");
        bus_write(9'h148, 32'h0000_0008, '0);
        check("R7 irq enabled", {31'b0, irq}, 1);
        bus_read(9'h148, 32'h0000_0008, "R7 enable readback");

        // R6: clear semantics
        bus_write(9'h144, 32'h0000_0000, '0);
        bus_read(9'h144, 32'h0000_0008, "R6 write zero keeps");
        bus_write(9'h144, 32'h0000_0008, '0);
        check("R6 irq after clear", {31'b0, irq}, 0);
        bus_read(9'h144, 32'h0, "R6 cleared");
        pulse_event(16'h0028);
        bus_read(9'h144, 32'h0000_0028, "R6 two events");
        bus_write(9'h144, 32'h0000_0028, 16'h0008);
        bus_read(9'h144, 32'h0000_0008, "R6 event beats clear");
        check("R7 irq after collision", {31'b0, irq}, 1);
        bus_write(9'h148, 32'h0000_0020, '0);
        check("R7 irq other mask", {31'b0, irq}, 0);

        // R8: paired loop bits
        bus_write(9'h150, 32'h0000_0004, '0);
        check("R8 low bit only", {16'b0, ch_loop}, 0);
        bus_write(9'h150, 32'h0004_0000, '0);
        check("R8 high bit only", {16'b0, ch_loop}, 0);
        bus_write(9'h150, 32'h0004_0004, '0);
        check("R8 both bits", {16'b0, ch_loop}, 32'h4);
        bus_read(9'h150, 32'h0004_0004, "R8 readback");
        bus_write(9'h150, 32'h0, '0);
        check("R8 disabled", {16'b0, ch_loop}, 0);

        // R9: unmapped and misaligned
        bus_write(9'h14C, 32'hFFFF_FFFF, '0);
        bus_write(9'h154, 32'hFFFF_FFFF, '0);
        bus_write(9'h052, 32'h1234_5678, '0);
        check("R9 no strobe", {ch_start, ch_stop}, 0);
        check("R9 loop unchanged", {16'b0, ch_loop}, 0);
        bus_read(9'h14C, 32'h0, "R9 read 0x14C");
        bus_read(9'h1FC, 32'h0, "R9 read 0x1FC");
        bus_read(9'h148, 32'h0000_0020, "R9 enable unchanged");
        bus_read(9'h050, 32'h8000_1000, "R9 misaligned ignored");
        bus_read(9'h150, 32'h0, "R9 loop register unchanged");

        // R10: rdata returns to zero
        @(negedge clk);
        check("R10 idle rdata", rdata, 0);

        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) check("R10 scoreboard drained", exp_q.size(), 0);
        done = 1'b1;
        finish_run();
    end

endmodule